// File: doc/BRIEF.md
# Base-Plus-Displacement Shift and Rotate Unit

This execution unit performs logical left shifts, logical right shifts and left rotates on a register operand. Each operation comes in a 32-bit (word) form and a 64-bit (doubleword) form. The shift amount is not an immediate field. It is the low six bits of an address-style sum: a base register value plus a sign-extended displacement. Base index zero selects a literal zero instead of the contents of register zero.

Each accepted operation produces one result beat. The beat carries the 64-bit result, a two-bit write mask and an illegal-operation flag. Mask bit 0 enables the low word of the destination and mask bit 1 enables the high word. For a word form only the low word is written, so the register file keeps the upper half of the destination. The unit never writes the source register. The source changes only when the register file routes the result back into that same register.

Both edges are valid/ready streams. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle and stays there until `out_ready` is seen high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. This gives one operation per cycle under full throughput. Back-pressure stalls the input with no extra buffering.

Top module: `shrot_unit`

## Requirements
- R1: The count is bits [5:0] of the 64-bit wrapping sum of the base value and the 20-bit displacement, sign-extended. All higher sum bits are ignored.
- R2: When `in_base_idx` is 0, the base value is taken as zero and `in_base_val` has no effect on the result.
- R3: Op 0 is a word logical left shift and op 1 is a word logical right shift. Both use only `in_src[31:0]` and fill vacated bits with zeros. A count of 32 to 63 gives a zero low word. Result bits [63:32] are zero and `out_wmask` is 2'b01.
- R4: Op 3 is a doubleword logical left shift and op 4 is a doubleword logical right shift. Both act on all 64 source bits and fill with zeros. `out_wmask` is 2'b11.
- R5: Op 2 rotates `in_src[31:0]` left by the count modulo 32. A count of 0 or 32 returns the word unchanged. Result bits [63:32] are zero and `out_wmask` is 2'b01.
- R6: Op 5 rotates all 64 source bits left by the count. `out_wmask` is 2'b11.
- R7: Ops 6 and 7 are illegal. They give a zero result, `out_wmask` 2'b00 and `out_illegal` 1. Legal ops give `out_illegal` 0.
- R8: `in_ready` equals `!out_valid || out_ready`. An accepted operation sets `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, all output fields hold still.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 3 | Operation select (0..5 legal) |
| in_base_idx | input | 4 | Base register field; 0 means literal zero |
| in_base_val | input | 64 | Value read from the base register |
| in_disp | input | 20 | Signed displacement |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Shifted or rotated value |
| out_wmask | output | 2 | Destination half enables: [0] low word, [1] high word |
| out_illegal | output | 1 | Operation select was unsupported |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 20-bit displacement and a 4-bit base index. With these values the six-bit count space is small enough to sweep in full. Every one of the 64 counts is run against all eight operation selects and three source patterns. This covers the word-form boundary at 32, the zero and full-width rotates, and both illegal codes. Directed cases use negative displacements and large base values to show the wrap and truncation of the count sum. One directed case changes the base value while the base index is zero. A stalled-consumer sequence exercises the ready rule and confirms the output holds while stalled.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    DIR_LEFT  = 2'd0,
    DIR_RIGHT = 2'd1,
    DIR_ROT   = 2'd2
  } shr_dir_e;

  typedef enum logic [2:0] {
    OP_SLL_W = 3'd0,
    OP_SRL_W = 3'd1,
    OP_ROL_W = 3'd2,
    OP_SLL_D = 3'd3,
    OP_SRL_D = 3'd4,
    OP_ROL_D = 3'd5
  } shr_op_e;

  localparam logic [1:0] WMASK_NONE = 2'b00;
  localparam logic [1:0] WMASK_LOW  = 2'b01;
  localparam logic [1:0] WMASK_ALL  = 2'b11;
endpackage

// File: rtl/shr_count_gen.sv
module shr_count_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 20,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(XLEN)
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [CNT_W-1:0]  cnt
);
  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] ea_sum;

  always_comb begin
    base_eff = (base_idx == '0) ? '0 : base_val;
    disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
    ea_sum   = base_eff + disp_ext;
    cnt      = ea_sum[CNT_W-1:0];
  end
endmodule

// File: rtl/shr_barrel.sv
module shr_barrel
  import shr_pkg::*;
#(
  parameter int W = 64,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [LG-1:0] amt,
  input  shr_dir_e      dir,
  output logic [W-1:0]  result
);
  logic [W-1:0] stage [LG+1];

  assign stage[0] = data;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      unique case (dir)
        DIR_LEFT:  moved = stage[s] << K;
        DIR_RIGHT: moved = stage[s] >> K;
        default:   moved = (stage[s] << K) | (stage[s] >> (W - K));
      endcase
    end
    assign stage[s+1] = amt[s] ? moved : stage[s];
  end

  assign result = stage[LG];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 20,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [IDX_W-1:0]  in_base_idx,
  input  logic [XLEN-1:0]   in_base_val,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [XLEN-1:0]   in_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_result,
  output logic [1:0]        out_wmask,
  output logic              out_illegal
);
  localparam int HALF  = XLEN / 2;
  localparam int CNT_W = $clog2(XLEN);
  localparam int HCW   = $clog2(HALF);

  logic [CNT_W-1:0] cnt;
  shr_dir_e         dir;
  logic             wide;
  logic             legal;
  logic [HALF-1:0]  narrow_res;
  logic [XLEN-1:0]  wide_res;
  logic [XLEN-1:0]  nxt_result;
  logic [1:0]       nxt_wmask;
  logic             narrow_zero;

  shr_count_gen #(
    .XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)
  ) u_cnt (
    .base_idx (in_base_idx),
    .base_val (in_base_val),
    .disp     (in_disp),
    .cnt      (cnt)
  );

  always_comb begin
    legal = 1'b1;
    wide  = 1'b0;
    dir   = DIR_LEFT;
    case (in_op)
      OP_SLL_W: dir = DIR_LEFT;
      OP_SRL_W: dir = DIR_RIGHT;
      OP_ROL_W: dir = DIR_ROT;
      OP_SLL_D: begin dir = DIR_LEFT;  wide = 1'b1; end
      OP_SRL_D: begin dir = DIR_RIGHT; wide = 1'b1; end
      OP_ROL_D: begin dir = DIR_ROT;   wide = 1'b1; end
      default:  legal = 1'b0;
    endcase
  end

  shr_barrel #(.W(HALF)) u_narrow (
    .data   (in_src[HALF-1:0]),
    .amt    (cnt[HCW-1:0]),
    .dir    (dir),
    .result (narrow_res)
  );

  shr_barrel #(.W(XLEN)) u_wide (
    .data   (in_src),
    .amt    (cnt),
    .dir    (dir),
    .result (wide_res)
  );

  // counts at or past the word width empty a word-form logical shift
  assign narrow_zero = cnt[CNT_W-1] && (dir != DIR_ROT);

  always_comb begin
    if (!legal) begin
      nxt_result = '0;
      nxt_wmask  = WMASK_NONE;
    end else if (wide) begin
      nxt_result = wide_res;
      nxt_wmask  = WMASK_ALL;
    end else begin
      nxt_result = {{HALF{1'b0}}, (narrow_zero ? {HALF{1'b0}} : narrow_res)};
      nxt_wmask  = WMASK_LOW;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wmask   <= WMASK_NONE;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_wmask   <= nxt_wmask;
        out_illegal <= !legal;
      end
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 20,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [IDX_W-1:0]  in_base_idx,
  input logic [XLEN-1:0]   in_base_val,
  input logic [DISP_W-1:0] in_disp,
  input logic [XLEN-1:0]   in_src,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_result,
  input logic [1:0]        out_wmask,
  input logic              out_illegal
);
  localparam int HALF = XLEN / 2;

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_wmask) && $stable(out_illegal)));

  // R8
  accept_to_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_wmask == 2'b00 && out_result == '0));

  // R7
  legal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_wmask == 2'b01 || out_wmask == 2'b11));

  // R3
  word_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wmask == 2'b01) |-> (out_result[XLEN-1:HALF] == '0));
endmodule

bind shrot_unit shrot_unit_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_base_idx = '0;
  logic [63:0] in_base_val = '0;
  logic [19:0] in_disp = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [1:0]  out_wmask;
  logic        out_illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shrot_unit dut (.*);

  function automatic logic [66:0] model(input int op, input logic [3:0] idx,
                                        input logic [63:0] bv, input logic [19:0] d,
                                        input logic [63:0] s);
    logic [63:0] sum;
    logic [63:0] r;
    int c;
    sum = ((idx == 4'd0) ? 64'd0 : bv) + {{44{d[19]}}, d};
    c = int'(sum[5:0]);
    r = '0;
    case (op)
      0: for (int i = 0; i < 32; i++) if (i >= c) r[i] = s[i-c];
      1: for (int i = 0; i < 32; i++) if (i + c < 32) r[i] = s[i+c];
      2: for (int i = 0; i < 32; i++) r[(i + c) % 32] = s[i];
      3: for (int i = 0; i < 64; i++) if (i >= c) r[i] = s[i-c];
      4: for (int i = 0; i < 64; i++) if (i + c < 64) r[i] = s[i+c];
      5: for (int i = 0; i < 64; i++) r[(i + c) % 64] = s[i];
      default: r = '0;
    endcase
    if (op <= 2) return {1'b0, 2'b01, r};
    if (op <= 5) return {1'b0, 2'b11, r};
    return {1'b1, 2'b00, 64'd0};
  endfunction

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual ill=%b mask=%b res=%h expected ill=%b mask=%b res=%h",
               tag, act[66], act[65:64], act[63:0], exp[66], exp[65:64], exp[63:0]);
    end
  endtask

  task automatic run_op(input string tag, input int op, input logic [3:0] idx,
                        input logic [63:0] bv, input logic [19:0] d, input logic [63:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_base_idx = idx;
    in_base_val = bv; in_disp = d; in_src = s;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {66'd0, out_valid}, 67'd1);
    check(tag, {out_illegal, out_wmask, out_result}, model(op, idx, bv, d, s));
  endtask

  initial begin
    logic [63:0] pats [3];
    logic [66:0] a_exp;
    pats[0] = 64'h8000_0001_F00F_0001;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {64'd0, out_valid, in_ready, 1'b0}, {64'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;

    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 64; c++) begin
        for (int p = 0; p < 3; p++) begin
          string tag;
          logic [19:0] d;
          case (op)
            0, 1: tag = "R3";
            2: tag = "R5";
            3, 4: tag = "R4";
            5: tag = "R6";
            default: tag = "R7";
          endcase
          // displacement with junk above the count bits, sometimes negative (R1)
          d = 20'(c) + 20'(p * 64) - ((p == 2) ? 20'd256 : 20'd0);
          run_op(tag, op, 4'd0, 64'hDEAD_BEEF_0000_0007, d, pats[p]);
        end
      end
    end

    // R1 base plus displacement, wrap and truncation
    run_op("R1 base+disp", 3, 4'd5, 64'hFFFF_FFFF_FFFF_FFFE, 20'h00003, pats[2]);
    run_op("R1 negative disp", 5, 4'd3, 64'h0000_0000_0000_0040, 20'hFFFFF, pats[0]);
    run_op("R1 high sum bits", 2, 4'd9, 64'h7FFF_FFFF_FFFF_FFC0, 20'h80021, pats[2]);
    // R2 base index zero ignores base value
    run_op("R2 idx0 a", 4, 4'd0, 64'h0000_0000_0000_0011, 20'd5, pats[1]);
    run_op("R2 idx0 b", 4, 4'd0, 64'h0000_0000_0000_0000, 20'd5, pats[1]);

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    run_op("R8 stalled first", 3, 4'd0, 64'd0, 20'd4, pats[2]);
    a_exp = model(3, 4'd0, 64'd0, 20'd4, pats[2]);
    in_valid = 1'b1; in_op = 3'd4; in_base_idx = 4'd0; in_disp = 20'd8; in_src = pats[0];
    check("R8 ready low", {66'd0, in_ready}, 67'd0);
    repeat (2) @(negedge clk);
    check("R8 held", {out_illegal, out_wmask, out_result}, a_exp);
    check("R8 still valid", {66'd0, out_valid}, 67'd1);
    out_ready = 1'b1;
    #0.1;
    check("R8 ready on drain", {66'd0, in_ready}, 67'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next beat", {out_illegal, out_wmask, out_result},
          model(4, 4'd0, 64'd0, 20'd8, pats[0]));
    @(negedge clk);
    check("R8 drained", {66'd0, out_valid}, 67'd0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule